// File: doc/BRIEF.md
# Low-Power Mode Controller

This block decides when the processor core, the peripherals and the main oscillator receive their enables while a small microcontroller is running, idle or powered down. Software asks for a low-power state with a one-cycle request. The core raises that request as the requesting instruction retires, so that instruction is the last one to finish before the mode takes hold. In idle the core clock is gated off while the peripheral clock and the oscillator keep running. In power-down all three are switched off.

Idle ends when any bit of the enabled-interrupt vector is set. The controller then restores the core clock and emits a one-cycle resume pulse so the core can vector to its service routine. Power-down ends only on a hardware reset, or on the external interrupt line when the wake-up enable bit is set. Any exit from power-down, and any reset, first passes through a stabilisation interval. During that interval the oscillator runs but the core stays held for a parameter-set number of cycles. The whole controller runs on a free-running backup clock that is never gated.

An external-interrupt exit from power-down ends with a resume pulse, because register contents were kept. An exit through reset ends without one, because the registers are reinitialised elsewhere.

Top module: `lpm_ctrl`

## Requirements
- R1: On a synchronous reset the controller enters stabilisation (cpu_clk_en=0, per_clk_en=0, osc_en=1, core_hold=1). After reset is released, core_hold stays high for exactly STAB_CYCLES backup-clock samples, counted from the first cycle after the last reset edge.
- R2: In the running state cpu_clk_en, per_clk_en and osc_en are all 1, and core_hold and resume_pulse are 0 unless R4 or R9 applies.
- R3: idle_req sampled high while running gives, from the next cycle, cpu_clk_en=0, per_clk_en=1, osc_en=1, core_hold=0.
- R4: While idle, a non-zero irq_vec returns the controller to running on the next cycle, with resume_pulse high for exactly that one cycle.
- R5: While idle with irq_vec zero, ext_irq, pd_req and idle_req have no effect, and the outputs keep their idle values.
- R6: pd_req sampled high while running gives, from the next cycle, cpu_clk_en=0, per_clk_en=0, osc_en=0, core_hold=0.
- R7: When idle_req and pd_req are high in the same cycle, power-down is entered.
- R8: In power-down, irq_vec has no effect, and ext_irq has no effect while pd_wake_en is 0.
- R9: In power-down, ext_irq with pd_wake_en=1 starts stabilisation on the next cycle (osc_en=1, core_hold=1, other enables 0). It lasts exactly STAB_CYCLES cycles and is followed by running with a one-cycle resume_pulse.
- R10: A stabilisation that began with reset ends in running without a resume_pulse, whichever state the reset interrupted.
- R11: idle_req and pd_req asserted during stabilisation are ignored.
- R12: Whenever osc_en is 0, cpu_clk_en and per_clk_en are 0, and core_hold only falls when cpu_clk_en becomes 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| aon_clk | input | 1 | Free-running backup clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| idle_req | input | 1 | One-cycle software request for idle |
| pd_req | input | 1 | One-cycle software request for power-down |
| irq_vec | input | IRQ_W | Enabled, pending interrupts; any set bit wakes idle |
| ext_irq | input | 1 | External interrupt line |
| pd_wake_en | input | 1 | Allows ext_irq to end power-down |
| cpu_clk_en | output | 1 | Core clock gate enable |
| per_clk_en | output | 1 | Peripheral clock gate enable |
| osc_en | output | 1 | Main oscillator enable |
| core_hold | output | 1 | Holds the core during oscillator stabilisation |
| resume_pulse | output | 1 | One-cycle pulse on an interrupt-driven resume |

## Verification
The bench sweeps every non-zero interrupt vector for an idle wake. A design that tests only one vector bit, or that stretches the resume pulse, is caught there. It measures the stabilisation length after reset, after a reset taken from idle or power-down, and after an interrupt wake, so an off-by-one count or a missing stabilisation after a reset wake shows up as a wrong length. It applies every combination of external interrupt, wake enable and interrupt vector during power-down, simultaneous requests, and requests during stabilisation. A design that wakes without the enable bit, lets idle win over power-down, or accepts requests while held leaves the expected state.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    typedef enum logic [1:0] {
        LP_RUN  = 2'd0,
        LP_IDLE = 2'd1,
        LP_PDN  = 2'd2,
        LP_STAB = 2'd3
    } lp_state_e;

    typedef struct packed {
        logic cpu;
        logic per;
        logic osc;
        logic hold;
    } lp_gates_t;

    function automatic lp_gates_t gates_for(lp_state_e s);
        lp_gates_t g;
        case (s)
            LP_RUN:  g = '{cpu: 1'b1, per: 1'b1, osc: 1'b1, hold: 1'b0};
            LP_IDLE: g = '{cpu: 1'b0, per: 1'b1, osc: 1'b1, hold: 1'b0};
            LP_PDN:  g = '{cpu: 1'b0, per: 1'b0, osc: 1'b0, hold: 1'b0};
            default: g = '{cpu: 1'b0, per: 1'b0, osc: 1'b1, hold: 1'b1};
        endcase
        return g;
    endfunction

endpackage

// File: rtl/lpm_stab_timer.sv
module lpm_stab_timer #(
    parameter int STAB_CYCLES = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    output logic done
);
    generate
        if (STAB_CYCLES <= 1) begin : g_single
            assign done = active;
        end else begin : g_count
            localparam int CNT_W = $clog2(STAB_CYCLES);
            localparam logic [CNT_W-1:0] LAST = CNT_W'(STAB_CYCLES - 1);

            logic [CNT_W-1:0] cnt_q;

            always_ff @(posedge clk) begin
                if (rst || !active) begin
                    cnt_q <= '0;
                end else if (cnt_q != LAST) begin
                    cnt_q <= cnt_q + CNT_W'(1);
                end
            end

            assign done = active && (cnt_q == LAST);

            AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
                active |-> (cnt_q <= LAST)); // R9
            AST_CNT_START: assert property (@(posedge clk) disable iff (rst)
                (active && !$past(active)) |-> (cnt_q == '0)); // R9
        end
    endgenerate
endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm
    import lpm_pkg::*;
#(
    parameter int IRQ_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             idle_req,
    input  logic             pd_req,
    input  logic [IRQ_W-1:0] irq_vec,
    input  logic             ext_irq,
    input  logic             pd_wake_en,
    input  logic             stab_done,
    output lp_state_e        state,
    output logic             resume
);
    lp_state_e st_q, st_d;
    logic      by_irq_q;
    logic      resume_q, resume_d;

    always_comb begin
        st_d     = st_q;
        resume_d = 1'b0;
        case (st_q)
            LP_RUN: begin
                if (pd_req)        st_d = LP_PDN;
                else if (idle_req) st_d = LP_IDLE;
            end
            LP_IDLE: begin
                if (|irq_vec) begin
                    st_d     = LP_RUN;
                    resume_d = 1'b1;
                end
            end
            LP_PDN: begin
                if (ext_irq && pd_wake_en) st_d = LP_STAB;
            end
            default: begin
                if (stab_done) begin
                    st_d     = LP_RUN;
                    resume_d = by_irq_q;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= LP_STAB;
            by_irq_q <= 1'b0;
            resume_q <= 1'b0;
        end else begin
            st_q     <= st_d;
            resume_q <= resume_d;
            if (st_q == LP_PDN && st_d == LP_STAB) by_irq_q <= 1'b1;
            else if (st_d == LP_RUN)               by_irq_q <= 1'b0;
        end
    end

    assign state  = st_q;
    assign resume = resume_q;

    AST_IDLE_WAKE: assert property (@(posedge clk) disable iff (rst)
        (st_q == LP_IDLE && |irq_vec) |=> (st_q == LP_RUN && resume_q)); // R4
    AST_PD_PRIORITY: assert property (@(posedge clk) disable iff (rst)
        (st_q == LP_RUN && pd_req) |=> (st_q == LP_PDN)); // R7
    AST_PD_STAYS: assert property (@(posedge clk) disable iff (rst)
        (st_q == LP_PDN && !(ext_irq && pd_wake_en)) |=> (st_q == LP_PDN)); // R8
    AST_STAB_IGNORES: assert property (@(posedge clk) disable iff (rst)
        (st_q == LP_STAB && !stab_done) |=> (st_q == LP_STAB)); // R11
    AST_PULSE_ONE: assert property (@(posedge clk) disable iff (rst)
        resume_q |=> !resume_q); // R4
endmodule

// File: rtl/lpm_gate_decode.sv
module lpm_gate_decode
    import lpm_pkg::*;
(
    input  lp_state_e state,
    output logic      cpu_en,
    output logic      per_en,
    output logic      osc_en,
    output logic      hold
);
    lp_gates_t g;

    always_comb begin
        g      = gates_for(state);
        cpu_en = g.cpu;
        per_en = g.per;
        osc_en = g.osc;
        hold   = g.hold;
    end
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
    import lpm_pkg::*;
#(
    parameter int IRQ_W       = 8,
    parameter int STAB_CYCLES = 1024
) (
    input  logic             aon_clk,
    input  logic             rst,
    input  logic             idle_req,
    input  logic             pd_req,
    input  logic [IRQ_W-1:0] irq_vec,
    input  logic             ext_irq,
    input  logic             pd_wake_en,
    output logic             cpu_clk_en,
    output logic             per_clk_en,
    output logic             osc_en,
    output logic             core_hold,
    output logic             resume_pulse
);
    lp_state_e state;
    logic      stab_done;

    lpm_fsm #(.IRQ_W(IRQ_W)) u_fsm (
        .clk        (aon_clk),
        .rst        (rst),
        .idle_req   (idle_req),
        .pd_req     (pd_req),
        .irq_vec    (irq_vec),
        .ext_irq    (ext_irq),
        .pd_wake_en (pd_wake_en),
        .stab_done  (stab_done),
        .state      (state),
        .resume     (resume_pulse)
    );

    lpm_stab_timer #(.STAB_CYCLES(STAB_CYCLES)) u_timer (
        .clk    (aon_clk),
        .rst    (rst),
        .active (state == LP_STAB),
        .done   (stab_done)
    );

    lpm_gate_decode u_dec (
        .state  (state),
        .cpu_en (cpu_clk_en),
        .per_en (per_clk_en),
        .osc_en (osc_en),
        .hold   (core_hold)
    );

    AST_OSC_GATES: assert property (@(posedge aon_clk) disable iff (rst)
        !osc_en |-> (!cpu_clk_en && !per_clk_en)); // R12
    AST_HOLD_RELEASE: assert property (@(posedge aon_clk) disable iff (rst)
        $fell(core_hold) |-> cpu_clk_en); // R12
    AST_IDLE_ENTRY: assert property (@(posedge aon_clk) disable iff (rst)
        (cpu_clk_en && !pd_req && idle_req) |=> (!cpu_clk_en && per_clk_en)); // R3
endmodule

// File: tb/lpm_ctrl_tb.sv
module lpm_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int IRQ_W      = 4;
    localparam int STAB       = 5;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             idle_req = 1'b0;
    logic             pd_req = 1'b0;
    logic [IRQ_W-1:0] irq_vec = '0;
    logic             ext_irq = 1'b0;
    logic             pd_wake_en = 1'b0;
    logic             cpu_clk_en, per_clk_en, osc_en, core_hold, resume_pulse;

    int nchk = 0;
    int nerr = 0;

    localparam logic [4:0] O_RUN   = 5'b11100;
    localparam logic [4:0] O_RESUM = 5'b11101;
    localparam logic [4:0] O_IDLE  = 5'b01100;
    localparam logic [4:0] O_PDN   = 5'b00000;
    localparam logic [4:0] O_STAB  = 5'b00110;

    always #(CLK_PERIOD/2) clk = ~clk;

    lpm_ctrl #(.IRQ_W(IRQ_W), .STAB_CYCLES(STAB)) u_dut (
        .aon_clk      (clk),
        .rst          (rst),
        .idle_req     (idle_req),
        .pd_req       (pd_req),
        .irq_vec      (irq_vec),
        .ext_irq      (ext_irq),
        .pd_wake_en   (pd_wake_en),
        .cpu_clk_en   (cpu_clk_en),
        .per_clk_en   (per_clk_en),
        .osc_en       (osc_en),
        .core_hold    (core_hold),
        .resume_pulse (resume_pulse)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [4:0] exp);
        logic [4:0] got;
        got = {cpu_clk_en, per_clk_en, osc_en, core_hold, resume_pulse};
        nchk++;
        if (got !== exp) begin
            nerr++;
            $display("FAIL %s: {cpu,per,osc,hold,pulse} actual=%b expected=%b", tag, got, exp);
        end
    endtask

    task automatic stab_len(input string tag);
        int n;
        n = 0;
        while (core_hold === 1'b1 && n < 1000) begin
            n++;
            step();
        end
        nchk++;
        if (n != STAB) begin
            nerr++;
            $display("FAIL %s: hold length actual=%0d expected=%0d", tag, n, STAB);
        end
    endtask

    task automatic go_idle();
        idle_req = 1'b1;
        step();
        idle_req = 1'b0;
    endtask

    task automatic go_pd(input logic with_idle);
        pd_req = 1'b1;
        idle_req = with_idle;
        step();
        pd_req = 1'b0;
        idle_req = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        step();
        rst = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL R1: watchdog expired actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        step();
        step();
        do_reset();
        chk("R1 reset state", O_STAB);
        stab_len("R1 reset hold");
        chk("R10 run after reset, no pulse", O_RUN);
        step();
        chk("R2 run steady", O_RUN);

        for (int v = 1; v < (1 << IRQ_W); v++) begin
            go_idle();
            chk("R3 idle entry", O_IDLE);
            irq_vec = IRQ_W'(v);
            step();
            irq_vec = '0;
            chk("R4 idle wake with pulse", O_RESUM);
            step();
            chk("R4 pulse one cycle", O_RUN);
        end

        go_idle();
        ext_irq = 1'b1;
        pd_req = 1'b1;
        idle_req = 1'b1;
        step();
        chk("R5 idle ignores ext/pd/idle", O_IDLE);
        ext_irq = 1'b0;
        pd_req = 1'b0;
        idle_req = 1'b0;
        step();
        chk("R5 idle held", O_IDLE);
        irq_vec = 4'b1000;
        step();
        irq_vec = '0;
        chk("R4 idle wake top bit", O_RESUM);
        step();

        for (int both = 0; both < 2; both++) begin
            go_pd(logic'(both));
            chk(both ? "R7 pd wins over idle" : "R6 pd entry", O_PDN);
            for (int c = 0; c < 8; c++) begin
                ext_irq = c[0];
                pd_wake_en = c[1];
                irq_vec = c[2] ? 4'b0101 : 4'b0000;
                if (!(c[0] && c[1])) begin
                    step();
                    chk("R8 pd ignores wake without enable", O_PDN);
                end
            end
            ext_irq = 1'b1;
            pd_wake_en = 1'b1;
            irq_vec = '0;
            step();
            ext_irq = 1'b0;
            pd_wake_en = 1'b0;
            chk("R9 stabilisation entry", O_STAB);
            idle_req = 1'b1;
            pd_req = 1'b1;
            stab_len("R11 requests ignored, R9 hold length");
            idle_req = 1'b0;
            pd_req = 1'b0;
            chk("R9 resume pulse after pd wake", O_RESUM);
            step();
            chk("R9 pulse one cycle", O_RUN);
        end

        go_idle();
        do_reset();
        chk("R10 reset from idle", O_STAB);
        stab_len("R10 hold after idle reset");
        chk("R10 no pulse after reset", O_RUN);

        go_pd(1'b0);
        do_reset();
        chk("R10 reset from pd", O_STAB);
        stab_len("R10 hold after pd reset");
        chk("R10 no pulse after pd reset", O_RUN);

        go_pd(1'b0);
        pd_wake_en = 1'b1;
        ext_irq = 1'b1;
        step();
        ext_irq = 1'b0;
        pd_wake_en = 1'b0;
        step();
        do_reset();
        chk("R10 reset during stabilisation", O_STAB);
        stab_len("R10 hold restarts");
        chk("R10 reset cancels pulse", O_RUN);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule